// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. The condition is only a test of one forwarded register against zero: either branch when it is zero, or branch when it is not zero. The equality test and the target adder both live in decode. A taken branch therefore redirects fetch in the same cycle it is resolved, and costs one fetch slot rather than three.

Two fetch policies are offered, chosen at build time. In the delayed policy, the one instruction after the branch always runs, unless the branch is marked cancelling. A cancelling branch carries a predicted direction, and its slot instruction is turned into a no-op when the actual outcome disagrees with that prediction. In the predict-not-taken policy, fetch carries on sequentially, and the sequential successor is nullified whenever the branch is taken. In both policies, nullifying means the control bits of that instruction's fetch/decode entry are cleared to zero, so it writes neither a register nor memory.

When the forwarded operand is not yet valid, as after a load-use hazard, the branch waits in decode. It issues no redirect and no squash, and the fetch/decode entry holds its contents.

Top module: `dbr_unit`

## Requirements
- R1: With br_valid=1 and opnd_ready=1, the branch is taken when br_on_nz=0 and opnd equals zero, or when br_on_nz=1 and opnd is not zero. pc_sel is 1 in that same cycle exactly when the branch is taken, where pc_sel=1 selects br_target as the next fetch address.
- R2: br_target always equals pc_plus4 + (br_ofs × 4), taken modulo 2^XLEN. pc_plus4 is the address of the slot instruction, and br_ofs is a word offset that is already sign-extended.
- R3: With br_valid=0, pc_sel and squash are both 0, whatever the other branch inputs carry.
- R4: With br_valid=1 and opnd_ready=0, hold is 1 and pc_sel and squash are both 0. id_ctrl keeps its value across the clock edge. hold is 0 in every other case.
- R5: In the delayed policy (MODE=0), a branch with br_cancel=0 never raises squash, so its slot instruction always executes.
- R6: In the delayed policy, a resolved branch with br_cancel=1 raises squash exactly when its actual direction differs from pred_taken.
- R7: In the predict-not-taken policy (MODE=1), a resolved branch raises squash exactly when it is taken. br_cancel and pred_taken have no effect on squash or pc_sel.
- R8: At each clock edge where hold=0, id_ctrl loads if_ctrl, or all zeros if squash=1.
- R9: While rst_n is low, id_ctrl is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A conditional branch occupies decode |
| br_on_nz | input | 1 | 0: branch if operand is zero; 1: branch if nonzero |
| br_cancel | input | 1 | Branch is the cancelling variant |
| pred_taken | input | 1 | Direction predicted for a cancelling branch |
| opnd_ready | input | 1 | Forwarded operand is valid this cycle |
| opnd | input | XLEN | Forwarded register operand |
| pc_plus4 | input | XLEN | Address following the branch |
| br_ofs | input | XLEN | Sign-extended word offset |
| if_ctrl | input | CTRL_W | Control bits of the instruction now in fetch |
| pc_sel | output | 1 | 1: next fetch address is br_target |
| br_target | output | XLEN | Branch target address |
| squash | output | 1 | Nullify the instruction now in fetch |
| hold | output | 1 | Branch waits for its operand; stall fetch/decode |
| id_ctrl | output | CTRL_W | Control bits of the fetch/decode entry |

## Verification
The bench runs the same stimulus into one instance of each policy and concentrates on the cases a resolver most easily gets wrong. These are the zero and nonzero sense with operands just off zero, a negative offset, and a target that wraps past the top of the address space. A polarity slip shows up as redirects on the wrong operands, and a missing shift as a target off by a factor of four. All four combinations of cancelling prediction and outcome are applied, together with a plain branch whose prediction bit is set. A design that compared against the wrong sense would nullify useful slots in the delayed policy, or consult the prediction in the predict-not-taken policy. A stalled branch whose stale operand would count as taken checks that nothing redirects early and that the fetch/decode entry neither loads nor clears until the operand arrives.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic {
    DBR_DELAYED = 1'b0,
    DBR_PNT     = 1'b1
  } dbr_mode_e;

endpackage

// File: rtl/dbr_zero_test.sv
module dbr_zero_test #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opnd,
  input  logic            on_nz,
  output logic            taken
);
  logic is_zero;

  always_comb begin
    is_zero = (opnd == '0);
    taken   = on_nz ? !is_zero : is_zero;
  end
endmodule

// File: rtl/dbr_target_add.sv
module dbr_target_add #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] word_ofs,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] byte_ofs;

  always_comb begin
    byte_ofs = {word_ofs[XLEN-3:0], 2'b00};
    target   = base + byte_ofs;
  end
endmodule

// File: rtl/dbr_squash_policy.sv
module dbr_squash_policy #(
  parameter dbr_pkg::dbr_mode_e MODE = dbr_pkg::DBR_DELAYED
) (
  input  logic resolve,
  input  logic taken,
  input  logic cancel,
  input  logic pred,
  output logic squash
);
  logic sq_delayed;
  logic sq_pnt;

  always_comb begin
    sq_delayed = resolve && cancel && (taken != pred);
    sq_pnt     = resolve && taken;
    squash     = (MODE == dbr_pkg::DBR_PNT) ? sq_pnt : sq_delayed;
  end
endmodule

// File: rtl/dbr_slot_reg.sv
module dbr_slot_reg #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash,
  input  logic              hold,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = squash || !hold;
    ctrl_d  = squash ? '0 : ctrl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit #(
  parameter int                 XLEN   = 32,
  parameter int                 CTRL_W = 8,
  parameter dbr_pkg::dbr_mode_e MODE   = dbr_pkg::DBR_DELAYED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_on_nz,
  input  logic              br_cancel,
  input  logic              pred_taken,
  input  logic              opnd_ready,
  input  logic [XLEN-1:0]   opnd,
  input  logic [XLEN-1:0]   pc_plus4,
  input  logic [XLEN-1:0]   br_ofs,
  input  logic [CTRL_W-1:0] if_ctrl,
  output logic              pc_sel,
  output logic [XLEN-1:0]   br_target,
  output logic              squash,
  output logic              hold,
  output logic [CTRL_W-1:0] id_ctrl
);
  logic cond_taken;
  logic resolve;

  always_comb begin
    resolve = br_valid && opnd_ready;
    hold    = br_valid && !opnd_ready;
    pc_sel  = resolve && cond_taken;
  end

  dbr_zero_test #(.XLEN(XLEN)) u_zero (
    .opnd  (opnd),
    .on_nz (br_on_nz),
    .taken (cond_taken)
  );

  dbr_target_add #(.XLEN(XLEN)) u_tgt (
    .base     (pc_plus4),
    .word_ofs (br_ofs),
    .target   (br_target)
  );

  dbr_squash_policy #(.MODE(MODE)) u_pol (
    .resolve (resolve),
    .taken   (cond_taken),
    .cancel  (br_cancel),
    .pred    (pred_taken),
    .squash  (squash)
  );

  dbr_slot_reg #(.CTRL_W(CTRL_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .squash  (squash),
    .hold    (hold),
    .ctrl_in (if_ctrl),
    .ctrl_q  (id_ctrl)
  );
endmodule

// File: rtl/dbr_unit_chk.sv
module dbr_unit_chk #(
  parameter int                 CTRL_W = 8,
  parameter dbr_pkg::dbr_mode_e MODE   = dbr_pkg::DBR_DELAYED
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic              br_cancel,
  input logic              pc_sel,
  input logic              squash,
  input logic              hold,
  input logic [CTRL_W-1:0] id_ctrl
);
  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!pc_sel && !squash));

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(id_ctrl));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> (!pc_sel && !squash && !hold));

  // R8
  squash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (id_ctrl == '0));

  generate
    if (MODE == dbr_pkg::DBR_DELAYED) begin : g_dly
      // R5
      plain_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_cancel |-> !squash);
    end else begin : g_pnt
      // R7
      pnt_squash_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> pc_sel);
      // R7
      pnt_taken_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel |-> squash);
    end
  endgenerate
endmodule

bind dbr_unit dbr_unit_chk #(.CTRL_W(CTRL_W), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_valid  (br_valid),
  .br_cancel (br_cancel),
  .pc_sel    (pc_sel),
  .squash    (squash),
  .hold      (hold),
  .id_ctrl   (id_ctrl)
);

// File: tb/dbr_unit_test.sv
`timescale 1ns/1ps
module dbr_unit_test;
  localparam int XLEN = 32;
  localparam int CW   = 8;

  typedef struct {
    logic          valid;
    logic          cancel;
    logic          sel;
    logic [XLEN-1:0] tgt;
    logic          sq_d;
    logic          sq_p;
    logic          hld;
    logic [CW-1:0] id_d;
    logic [CW-1:0] id_p;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic br_valid, br_on_nz, br_cancel, pred_taken, opnd_ready;
  logic [XLEN-1:0] opnd, pc_plus4, br_ofs;
  logic [CW-1:0] if_ctrl;
  logic pc_sel_d, squash_d, hold_d, pc_sel_p, squash_p, hold_p;
  logic [XLEN-1:0] tgt_d, tgt_p;
  logic [CW-1:0] id_d, id_p;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit reported = 0;
  logic [CW-1:0] m_id_d, m_id_p;

  always #4 clk = ~clk;

  dbr_unit #(.XLEN(XLEN), .CTRL_W(CW), .MODE(dbr_pkg::DBR_DELAYED)) uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_on_nz(br_on_nz),
    .br_cancel(br_cancel), .pred_taken(pred_taken), .opnd_ready(opnd_ready),
    .opnd(opnd), .pc_plus4(pc_plus4), .br_ofs(br_ofs), .if_ctrl(if_ctrl),
    .pc_sel(pc_sel_d), .br_target(tgt_d), .squash(squash_d), .hold(hold_d),
    .id_ctrl(id_d));

  dbr_unit #(.XLEN(XLEN), .CTRL_W(CW), .MODE(dbr_pkg::DBR_PNT)) uut_pnt (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_on_nz(br_on_nz),
    .br_cancel(br_cancel), .pred_taken(pred_taken), .opnd_ready(opnd_ready),
    .opnd(opnd), .pc_plus4(pc_plus4), .br_ofs(br_ofs), .if_ctrl(if_ctrl),
    .pc_sel(pc_sel_p), .br_target(tgt_p), .squash(squash_p), .hold(hold_p),
    .id_ctrl(id_p));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic drive(input logic v, input logic nz, input logic cn, input logic pr,
                       input logic rdy, input logic [XLEN-1:0] op,
                       input logic [XLEN-1:0] pc, input logic [XLEN-1:0] ofs,
                       input logic [CW-1:0] ifc);
    exp_t e;
    logic tk, res;
    @(negedge clk);
    br_valid = v; br_on_nz = nz; br_cancel = cn; pred_taken = pr;
    opnd_ready = rdy; opnd = op; pc_plus4 = pc; br_ofs = ofs; if_ctrl = ifc;
    tk  = nz ? (op != 0) : (op == 0);
    res = v && rdy;
    e.valid  = v;
    e.cancel = cn;
    e.sel    = res && tk;
    e.tgt    = pc + ofs * 4;
    e.sq_d   = res && cn && (tk != pr);
    e.sq_p   = res && tk;
    e.hld    = v && !rdy;
    e.id_d   = m_id_d;
    e.id_p   = m_id_p;
    q.push_back(e);
    if (e.sq_d) m_id_d = '0; else if (!e.hld) m_id_d = ifc;
    if (e.sq_p) m_id_p = '0; else if (!e.hld) m_id_p = ifc;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(pc_sel_d == e.sel, e.valid ? "R1" : "R3", "pc_sel dly", pc_sel_d, e.sel);
        check(pc_sel_p == e.sel, e.valid ? "R1" : "R3", "pc_sel pnt", pc_sel_p, e.sel);
        check(tgt_d == e.tgt, "R2", "target dly", tgt_d, e.tgt);
        check(tgt_p == e.tgt, "R2", "target pnt", tgt_p, e.tgt);
        check(squash_d == e.sq_d, !e.valid ? "R3" : (e.cancel ? "R6" : "R5"),
              "squash dly", squash_d, e.sq_d);
        check(squash_p == e.sq_p, !e.valid ? "R3" : "R7", "squash pnt", squash_p, e.sq_p);
        check(hold_d == e.hld, "R4", "hold dly", hold_d, e.hld);
        check(hold_p == e.hld, "R4", "hold pnt", hold_p, e.hld);
        check(id_d == e.id_d, "R8", "id_ctrl dly", id_d, e.id_d);
        check(id_p == e.id_p, "R8", "id_ctrl pnt", id_p, e.id_p);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    br_valid = 0; br_on_nz = 0; br_cancel = 0; pred_taken = 0; opnd_ready = 1;
    opnd = '0; pc_plus4 = '0; br_ofs = '0; if_ctrl = 8'h3C;
    m_id_d = '0; m_id_p = '0;
    repeat (3) @(negedge clk);
    #2;
    // R9: reset state
    check(id_d == '0, "R9", "id_ctrl dly in reset", id_d, 0);
    check(id_p == '0, "R9", "id_ctrl pnt in reset", id_p, 0);
    @(negedge clk);
    if_ctrl = '0;
    rst_n = 1'b1;
    // R3 idle
    drive(0, 0, 0, 0, 1, 32'h0, 32'h1000, 32'h3, 8'h5A);
    // R1 zero sense taken, R5 plain slot
    drive(1, 0, 0, 0, 1, 32'h0, 32'h1000, 32'h3, 8'h11);
    // R1 zero sense, operand just off zero
    drive(1, 0, 0, 0, 1, 32'h1, 32'h1004, 32'h3, 8'h22);
    // R1 nonzero sense taken, R2 negative offset
    drive(1, 1, 0, 0, 1, 32'h8000_0000, 32'h2000, 32'hFFFF_FFFC, 8'h33);
    // R1 nonzero sense not taken
    drive(1, 1, 0, 0, 1, 32'h0, 32'h2004, 32'h10, 8'h44);
    // R4 operand not ready, stale operand would be taken
    drive(1, 0, 1, 1, 0, 32'h0, 32'h3000, 32'h8, 8'hFF);
    drive(1, 0, 1, 0, 0, 32'h0, 32'h3000, 32'h8, 8'hEE);
    drive(1, 0, 1, 0, 1, 32'h0, 32'h3000, 32'h8, 8'h55);
    // R6 cancelling: all four prediction/outcome pairs
    drive(1, 0, 1, 1, 1, 32'h0, 32'h4000, 32'h2, 8'h66);
    drive(1, 0, 1, 1, 1, 32'h9, 32'h4004, 32'h2, 8'h77);
    drive(1, 1, 1, 0, 1, 32'h9, 32'h4008, 32'h2, 8'h88);
    drive(1, 1, 1, 0, 1, 32'h0, 32'h400C, 32'h2, 8'h99);
    // R5 plain branch with prediction set, not taken
    drive(1, 1, 0, 1, 1, 32'h0, 32'h5000, 32'h1, 8'hAB);
    // R7 plain taken with prediction set
    drive(1, 1, 0, 1, 1, 32'h2, 32'h5004, 32'h1, 8'hCD);
    // R2 wrap past top
    drive(1, 0, 0, 0, 1, 32'h5, 32'hFFFF_FFF0, 32'h8, 8'h12);
    // R3 not valid with a taken-looking operand
    drive(0, 0, 1, 0, 1, 32'h0, 32'h6000, 32'h4, 8'h34);
    drive(0, 1, 0, 0, 1, 32'h0, 32'h6000, 32'h4, 8'h56);
    drive(0, 0, 0, 0, 1, 32'h0, 32'h6004, 32'h0, 8'h00);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule